// File: doc/BRIEF.md
# Framed TDM Audio Serial Port

This block moves audio words between a framed time-division multiplexed serial link and two word streams inside the chip. A bit clock, sampled in the system clock domain, sets the timing of every serial bit. A one-bit-clock frame-sync strobe starts each frame. A frame carries a fixed number of equal-width slots. For each slot, a received word is handed out on a valid/ready stream together with its slot number. Words taken from a second valid/ready stream are shifted out in step with the inbound data.

A per-slot enable mask limits traffic to the slots that carry audio. A slot that is switched off produces no received word, takes no transmit word and drives zeros on the line. The mask is held in two copies. Software writes only the pending copy, and reading the configuration returns that pending copy. The copy that governs the line changes only on the system clock cycle in which frame sync is seen. The mask can therefore be rewritten at any moment without disturbing the frame in progress.

Top module: `tdm_audio_port`

## Requirements
- R1: A frame begins when `fsync` is high at a bit-clock rising edge. That edge carries no data. The next SLOT_COUNT×SLOT_BITS rising edges carry slot 0 bit 0 through the last bit of the last slot, with the MSB of each slot first.
- R2: When an enabled slot has received all its bits, `rx_valid` rises with `rx_data` holding the word (first bit in the MSB) and `rx_slot` holding the 3-bit slot index (0 to 7).
- R3: An unaccepted received word holds `rx_valid`, `rx_data` and `rx_slot` steady while `rx_ready` is low. A later completed word replaces it.
- R4: In an enabled slot, `sdout` carries the next word taken from the transmit stream, MSB first. Each bit is presented after the bit-clock falling edge that precedes its receive rising edge. `sdout` changes only after a falling edge.
- R5: In a disabled slot (mask bit s = 0 for slot s), no received word appears, `sdout` is 0, and no transmit word is consumed.
- R6: An enabled transmit slot that finds no word available is sent as all zeros and sets `tx_underflow`. The flag stays set until reset.
- R7: A write to `cfg_wr_mask` lands in the pending copy. `cfg_rd_mask` returns the pending copy, and `swap_pending` goes high. The frame in progress keeps using the active copy.
- R8: On the cycle in which frame sync is detected, the active mask takes the pending value and `swap_pending` clears. A write in that same cycle stays pending for the following frame.
- R9: After reset, `sdout`, `rx_valid`, `tx_underflow` and `swap_pending` are 0, `tx_ready` is 1, and both mask copies hold all ones.
- R10: After the last bit of a frame and before the next frame sync, `sdout` is 0 and nothing is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Serial bit clock, already synchronous to clk |
| fsync | input | 1 | Frame-sync strobe, sampled on bclk rise |
| sdin | input | 1 | Inbound serial data |
| sdout | output | 1 | Outbound serial data |
| cfg_wr_en | input | 1 | Write strobe for the slot mask |
| cfg_wr_mask | input | SLOT_COUNT | Mask value to write (bit s enables slot s) |
| cfg_rd_mask | output | SLOT_COUNT | Pending mask copy |
| swap_pending | output | 1 | A written mask awaits the next frame sync |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word accepted when high with tx_valid |
| tx_data | input | SLOT_BITS | Transmit word |
| tx_underflow | output | 1 | Sticky: an enabled slot went out empty |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer takes the received word |
| rx_data | output | SLOT_BITS | Received word |
| rx_slot | output | $clog2(SLOT_COUNT) | Slot index of the received word |

## Verification
The bench rewrites the mask in the middle of a frame. A design that swapped copies at once would then drop slots from a frame that had already started. The bench also writes on the exact cycle of the swap, where a design that gave the write priority would apply the new mask one frame early or clear `swap_pending` too soon. Frames are run with a sparse mask, with too few transmit words and with the consumer stalled. These expose designs that consume transmit words in disabled slots, send stale data instead of zeros, or lose the newest received word. Every outbound bit and every inbound word is compared against values computed from the slot patterns.

// File: rtl/tdm_port_pkg.sv
package tdm_port_pkg;
  parameter int unsigned DEF_SLOT_BITS  = 16;
  parameter int unsigned DEF_SLOT_COUNT = 8;

  // Bit-clock events seen in the system clock domain
  typedef struct packed {
    logic rise;
    logic fall;
    logic start;   // rising edge with frame sync high
  } bclk_evt_t;
endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
  import tdm_port_pkg::*;
#(
  parameter int unsigned SLOT_BITS  = DEF_SLOT_BITS,
  parameter int unsigned SLOT_COUNT = DEF_SLOT_COUNT,
  localparam int unsigned BIT_W  = $clog2(SLOT_BITS),
  localparam int unsigned SLOT_W = $clog2(SLOT_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk,
  input  logic              fsync,
  output bclk_evt_t         evt,
  output logic              in_frame,
  output logic [BIT_W-1:0]  bit_idx,
  output logic [SLOT_W-1:0] slot_idx
);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(SLOT_BITS - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_COUNT - 1);

  logic              bclk_q;
  logic              in_frame_n;
  logic [BIT_W-1:0]  bit_n;
  logic [SLOT_W-1:0] slot_n;

  always_comb begin
    evt.rise  = bclk & ~bclk_q;
    evt.fall  = ~bclk & bclk_q;
    evt.start = evt.rise & fsync;
  end

  always_comb begin
    in_frame_n = in_frame;
    bit_n      = bit_idx;
    slot_n     = slot_idx;
    if (evt.start) begin
      in_frame_n = 1'b1;
      bit_n      = '0;
      slot_n     = '0;
    end else if (evt.rise && in_frame) begin
      if (bit_idx == BIT_LAST) begin
        bit_n = '0;
        if (slot_idx == SLOT_LAST) begin
          in_frame_n = 1'b0;
          slot_n     = '0;
        end else begin
          slot_n = slot_idx + 1'b1;
        end
      end else begin
        bit_n = bit_idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q   <= 1'b0;
      in_frame <= 1'b0;
      bit_idx  <= '0;
      slot_idx <= '0;
    end else begin
      bclk_q   <= bclk;
      in_frame <= in_frame_n;
      bit_idx  <= bit_n;
      slot_idx <= slot_n;
    end
  end
endmodule

// File: rtl/tdm_cfg_shadow.sv
module tdm_cfg_shadow #(
  parameter int unsigned SLOT_COUNT = 8,
  parameter logic [SLOT_COUNT-1:0] RESET_MASK = '1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SLOT_COUNT-1:0] wr_mask,
  input  logic                  swap,
  output logic [SLOT_COUNT-1:0] pending_mask,
  output logic [SLOT_COUNT-1:0] active_mask,
  output logic                  swap_pending
);
  logic [SLOT_COUNT-1:0] pending_n;
  logic [SLOT_COUNT-1:0] active_n;
  logic                  flag_n;

  always_comb begin
    pending_n = pending_mask;
    active_n  = active_mask;
    flag_n    = swap_pending;
    // Swap takes the registered pending value; a same-cycle write waits a frame
    if (swap) begin
      active_n = pending_mask;
      flag_n   = 1'b0;
    end
    if (wr_en) begin
      pending_n = wr_mask;
      flag_n    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_mask <= RESET_MASK;
      active_mask  <= RESET_MASK;
      swap_pending <= 1'b0;
    end else begin
      pending_mask <= pending_n;
      active_mask  <= active_n;
      swap_pending <= flag_n;
    end
  end
endmodule

// File: rtl/tdm_rx_lane.sv
module tdm_rx_lane #(
  parameter int unsigned SLOT_BITS  = 16,
  parameter int unsigned SLOT_COUNT = 8,
  localparam int unsigned SLOT_W = $clog2(SLOT_COUNT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_en,
  input  logic                 last_bit,
  input  logic [SLOT_W-1:0]    slot_idx,
  input  logic                 sdin,
  input  logic                 rx_ready,
  output logic                 rx_valid,
  output logic [SLOT_BITS-1:0] rx_data,
  output logic [SLOT_W-1:0]    rx_slot
);
  logic [SLOT_BITS-2:0] shreg_q, shreg_n;
  logic                 valid_n;
  logic [SLOT_BITS-1:0] data_n;
  logic [SLOT_W-1:0]    slot_n;
  logic                 word_done;

  assign word_done = sample_en & last_bit;

  always_comb begin
    shreg_n = shreg_q;
    data_n  = rx_data;
    slot_n  = rx_slot;
    valid_n = rx_valid & ~rx_ready;
    if (word_done) begin
      data_n  = {shreg_q, sdin};
      slot_n  = slot_idx;
      valid_n = 1'b1;
    end else if (sample_en) begin
      shreg_n = {shreg_q[SLOT_BITS-3:0], sdin};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q  <= '0;
      rx_data  <= '0;
      rx_slot  <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (sample_en) shreg_q <= shreg_n;
      if (word_done) begin
        rx_data <= data_n;
        rx_slot <= slot_n;
      end
      rx_valid <= valid_n;
    end
  end
endmodule

// File: rtl/tdm_tx_lane.sv
module tdm_tx_lane #(
  parameter int unsigned SLOT_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fall,
  input  logic                 in_frame,
  input  logic                 first_bit,
  input  logic                 slot_en,
  input  logic                 tx_valid,
  input  logic [SLOT_BITS-1:0] tx_data,
  output logic                 tx_ready,
  output logic                 sdout,
  output logic                 tx_underflow
);
  logic [SLOT_BITS-1:0] hold_q;
  logic                 hold_vld;
  logic [SLOT_BITS-2:0] shreg_q, shreg_n;
  logic                 sdout_n;
  logic                 load_slot;
  logic                 consume;
  logic                 accept;
  logic                 uf_set;
  logic [SLOT_BITS-1:0] word;

  assign tx_ready  = ~hold_vld;
  assign accept    = tx_valid & ~hold_vld;
  assign load_slot = fall & in_frame & first_bit;
  assign consume   = load_slot & slot_en & hold_vld;
  assign uf_set    = load_slot & slot_en & ~hold_vld;

  always_comb begin
    word    = (slot_en && hold_vld) ? hold_q : '0;
    sdout_n = sdout;
    shreg_n = shreg_q;
    if (load_slot) begin
      sdout_n = word[SLOT_BITS-1];
      shreg_n = word[SLOT_BITS-2:0];
    end else if (fall && in_frame) begin
      sdout_n = shreg_q[SLOT_BITS-2];
      shreg_n = {shreg_q[SLOT_BITS-3:0], 1'b0};
    end else if (fall) begin
      sdout_n = 1'b0;
      shreg_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q       <= '0;
      hold_vld     <= 1'b0;
      shreg_q      <= '0;
      sdout        <= 1'b0;
      tx_underflow <= 1'b0;
    end else begin
      if (accept) hold_q <= tx_data;
      if (accept) hold_vld <= 1'b1;
      else if (consume) hold_vld <= 1'b0;
      if (fall) begin
        shreg_q <= shreg_n;
        sdout   <= sdout_n;
      end
      if (uf_set) tx_underflow <= 1'b1;
    end
  end
endmodule

// File: rtl/tdm_audio_port.sv
module tdm_audio_port
  import tdm_port_pkg::*;
#(
  parameter int unsigned SLOT_BITS  = DEF_SLOT_BITS,
  parameter int unsigned SLOT_COUNT = DEF_SLOT_COUNT,
  localparam int unsigned SLOT_W = $clog2(SLOT_COUNT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bclk,
  input  logic                  fsync,
  input  logic                  sdin,
  output logic                  sdout,
  input  logic                  cfg_wr_en,
  input  logic [SLOT_COUNT-1:0] cfg_wr_mask,
  output logic [SLOT_COUNT-1:0] cfg_rd_mask,
  output logic                  swap_pending,
  input  logic                  tx_valid,
  output logic                  tx_ready,
  input  logic [SLOT_BITS-1:0]  tx_data,
  output logic                  tx_underflow,
  output logic                  rx_valid,
  input  logic                  rx_ready,
  output logic [SLOT_BITS-1:0]  rx_data,
  output logic [SLOT_W-1:0]     rx_slot
);
  localparam int unsigned BIT_W = $clog2(SLOT_BITS);

  bclk_evt_t             evt;
  logic                  in_frame;
  logic [BIT_W-1:0]      bit_idx;
  logic [SLOT_W-1:0]     slot_idx;
  logic [SLOT_COUNT-1:0] active_mask;
  logic                  slot_en;
  logic                  rx_sample;

  tdm_frame_timer #(.SLOT_BITS(SLOT_BITS), .SLOT_COUNT(SLOT_COUNT)) u_timer (
    .clk, .rst_n, .bclk, .fsync,
    .evt, .in_frame, .bit_idx, .slot_idx
  );

  tdm_cfg_shadow #(.SLOT_COUNT(SLOT_COUNT)) u_cfg (
    .clk, .rst_n,
    .wr_en        (cfg_wr_en),
    .wr_mask      (cfg_wr_mask),
    .swap         (evt.start),
    .pending_mask (cfg_rd_mask),
    .active_mask  (active_mask),
    .swap_pending (swap_pending)
  );

  assign slot_en   = active_mask[slot_idx];
  assign rx_sample = evt.rise & ~evt.start & in_frame & slot_en;

  tdm_rx_lane #(.SLOT_BITS(SLOT_BITS), .SLOT_COUNT(SLOT_COUNT)) u_rx (
    .clk, .rst_n,
    .sample_en (rx_sample),
    .last_bit  (bit_idx == BIT_W'(SLOT_BITS - 1)),
    .slot_idx  (slot_idx),
    .sdin, .rx_ready, .rx_valid, .rx_data, .rx_slot
  );

  tdm_tx_lane #(.SLOT_BITS(SLOT_BITS)) u_tx (
    .clk, .rst_n,
    .fall      (evt.fall),
    .in_frame  (in_frame),
    .first_bit (bit_idx == '0),
    .slot_en   (slot_en),
    .tx_valid, .tx_data, .tx_ready, .sdout, .tx_underflow
  );
endmodule

// File: rtl/tdm_audio_port_chk.sv
module tdm_audio_port_chk #(
  parameter int unsigned SLOT_BITS  = 16,
  parameter int unsigned SLOT_COUNT = 8,
  localparam int unsigned SLOT_W = $clog2(SLOT_COUNT)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bclk,
  input logic                  fsync,
  input logic                  sdout,
  input logic                  cfg_wr_en,
  input logic [SLOT_COUNT-1:0] cfg_rd_mask,
  input logic                  swap_pending,
  input logic                  tx_underflow,
  input logic                  rx_valid,
  input logic                  rx_ready,
  input logic [SLOT_BITS-1:0]  rx_data,
  input logic [SLOT_W-1:0]     rx_slot
);
  // R3: a stalled word stays put
  a_r3_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid);

  // R4: line output moves only after a bit-clock falling edge
  a_r4_sdout_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdout) |-> (!$past(bclk) && $past(bclk, 2)));

  // R6: underflow is sticky
  a_r6_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underflow |=> tx_underflow);

  // R7: a write always leaves a swap waiting
  a_r7_write_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> swap_pending);

  // R7: pending copy changes only through a write
  a_r7_readback_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_rd_mask) |-> $past(cfg_wr_en));

  // R8: the waiting flag clears only on a frame-sync rising edge
  a_r8_swap_on_fsync: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(swap_pending) |-> ($past(fsync) && $past(bclk) && !$past(bclk, 2)));
endmodule

bind tdm_audio_port tdm_audio_port_chk #(.SLOT_BITS(SLOT_BITS), .SLOT_COUNT(SLOT_COUNT)) u_chk (.*);

// File: tb/tb_tdm_audio_port.sv
module tb_tdm_audio_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0;
  logic        fsync = 1'b0;
  logic        sdin = 1'b0;
  logic        sdout;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_wr_mask = '0;
  logic [7:0]  cfg_rd_mask;
  logic        swap_pending;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [15:0] tx_data = '0;
  logic        tx_underflow;
  logic        rx_valid;
  logic        rx_ready = 1'b1;
  logic [15:0] rx_data;
  logic [2:0]  rx_slot;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [15:0] tx_q [0:63];
  int tx_n = 0;
  int tx_idx = 0;
  int exp_ptr = 0;
  logic [15:0] got_data [0:63];
  logic [2:0]  got_slot [0:63];
  int got_n = 0;

  always #5 clk = ~clk;

  tdm_audio_port dut (
    .clk, .rst_n, .bclk, .fsync, .sdin, .sdout,
    .cfg_wr_en, .cfg_wr_mask, .cfg_rd_mask, .swap_pending,
    .tx_valid, .tx_ready, .tx_data, .tx_underflow,
    .rx_valid, .rx_ready, .rx_data, .rx_slot
  );

  always @(posedge clk) begin
    if (tx_valid && tx_ready) tx_idx <= tx_idx + 1;
    if (rx_valid && rx_ready) begin
      got_data[got_n] <= rx_data;
      got_slot[got_n] <= rx_slot;
      got_n <= got_n + 1;
    end
  end

  always @(negedge clk) begin
    tx_valid = (tx_idx < tx_n);
    tx_data  = tx_q[tx_idx % 64];
  end

  function automatic logic [15:0] pat(input int seed, input int s);
    return 16'(seed * 40503 + s * 4369) ^ 16'h8001;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic add_tx(input int n);
    for (int i = 0; i < n; i++) begin
      tx_q[tx_n % 64] = 16'(tx_n * 7919 + 16'h1234);
      tx_n++;
    end
  endtask

  task automatic write_mask(input logic [7:0] m);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_mask = m;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  // One bit-clock period: low half then high half (2 clk each)
  task automatic bit_cycle(input logic fs, input logic din, input bit wr,
                           input logic [7:0] wv, output logic sd);
    @(negedge clk);
    bclk = 1'b0; fsync = fs; sdin = din; cfg_wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    sd = sdout;
    bclk = 1'b1;
    if (wr) begin cfg_wr_en = 1'b1; cfg_wr_mask = wv; end
    @(negedge clk);
    cfg_wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_frame(input logic [7:0] mask, input int seed, input int wr_bit,
                           input logic [7:0] wr_val, input bit wr_swap, input bit expect_rx);
    int base;
    int exp_cnt;
    int k;
    logic sd;
    logic [15:0] cur;
    int bad;
    base = got_n;
    bad = 0;
    bit_cycle(1'b1, 1'b0, wr_swap, wr_val, sd);
    for (int s = 0; s < 8; s++) begin
      for (int b = 0; b < 16; b++) begin
        if (b == 0) begin
          if (mask[s]) begin
            if (exp_ptr < tx_n) begin cur = tx_q[exp_ptr % 64]; exp_ptr++; end
            else cur = '0;
          end else cur = '0;
        end
        logic_bit: begin
          logic d;
          d = pat(seed, s)[15-b];
          bit_cycle(1'b0, d, (s*16+b) == wr_bit, wr_val, sd);
        end
        // R1 R4 R5 R6: outbound bit for slot s, bit b
        chk(sd === cur[15-b], "R4", {31'b0, sd}, {31'b0, cur[15-b]});
        if (sd !== cur[15-b]) bad++;
      end
    end
    // R10: idle bit clocks after the frame
    for (int i = 0; i < 4; i++) begin
      bit_cycle(1'b0, 1'b1, 1'b0, 8'h00, sd);
      chk(sd === 1'b0, "R10", {31'b0, sd}, 32'd0);
    end
    repeat (4) @(negedge clk);
    if (expect_rx) begin
      exp_cnt = $countones(mask);
      // R5: only enabled slots produce words
      chk(got_n - base == exp_cnt, "R5", got_n - base, exp_cnt);
      k = base;
      for (int s = 0; s < 8; s++) begin
        if (mask[s] && k < got_n) begin
          // R1 R2: word content and slot tag
          chk(got_data[k % 64] === pat(seed, s), "R2", got_data[k % 64], pat(seed, s));
          chk(got_slot[k % 64] === 3'(s), "R2", got_slot[k % 64], s);
          k++;
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk(sdout === 1'b0, "R9", sdout, 0);
    chk(rx_valid === 1'b0, "R9", rx_valid, 0);
    chk(tx_ready === 1'b1, "R9", tx_ready, 1);
    chk(tx_underflow === 1'b0, "R9", tx_underflow, 0);
    chk(swap_pending === 1'b0, "R9", swap_pending, 0);
    chk(cfg_rd_mask === 8'hFF, "R9", cfg_rd_mask, 8'hFF);

    // Frame 1: all slots enabled
    add_tx(8);
    run_frame(8'hFF, 1, -1, 8'h00, 1'b0, 1'b1);

    // Frame 2: mask rewritten mid-frame; frame keeps old mask (R7)
    add_tx(8);
    run_frame(8'hFF, 2, 40, 8'hA5, 1'b0, 1'b1);
    chk(cfg_rd_mask === 8'hA5, "R7", cfg_rd_mask, 8'hA5);
    chk(swap_pending === 1'b1, "R7", swap_pending, 1);

    // Frame 3: sparse mask adopted at frame sync (R8, R5)
    add_tx(4);
    run_frame(8'hA5, 3, -1, 8'h00, 1'b0, 1'b1);
    chk(swap_pending === 1'b0, "R8", swap_pending, 0);
    chk(tx_underflow === 1'b0, "R6", tx_underflow, 0);

    // Frame 4: write at the swap cycle; starved transmit; stalled receive
    write_mask(8'h0F);
    rx_ready = 1'b0;
    add_tx(2);
    run_frame(8'h0F, 4, -1, 8'h3C, 1'b1, 1'b0);
    chk(swap_pending === 1'b1, "R8", swap_pending, 1);
    chk(cfg_rd_mask === 8'h3C, "R8", cfg_rd_mask, 8'h3C);
    chk(tx_underflow === 1'b1, "R6", tx_underflow, 1);
    // R3: newest stalled word holds: slot 3
    chk(rx_valid === 1'b1, "R3", rx_valid, 1);
    chk(rx_data === pat(4, 3), "R3", rx_data, pat(4, 3));
    chk(rx_slot === 3'd3, "R3", rx_slot, 3);
    repeat (6) @(negedge clk);
    chk(rx_data === pat(4, 3) && rx_valid === 1'b1, "R3", rx_data, pat(4, 3));
    rx_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(rx_valid === 1'b0, "R3", rx_valid, 0);

    // Frame 5: mask written at the swap now active
    add_tx(8);
    run_frame(8'h3C, 5, -1, 8'h00, 1'b0, 1'b1);
    chk(swap_pending === 1'b0, "R8", swap_pending, 0);
    chk(tx_underflow === 1'b1, "R6", tx_underflow, 1);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule